// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the datapath half of a small 32-bit load/store processor that runs each instruction over several clock cycles. The instruction subset is word load, word store, register-register add/sub/and/or/set-less-than, branch-if-equal and unconditional jump. One memory port serves both instruction fetch and data access, and one ALU does all the arithmetic. In separate cycles it computes the incremented PC, the branch target, the effective address and the register-register result. Holding registers sit between the cycles: an instruction register, a memory data register, two operand registers and an ALU result register. They keep each unit's output until a later cycle uses it.

The datapath has no sequencer of its own. Every multiplexer select and every write enable comes from an external control bundle that a separate state machine drives one cycle at a time. The held instruction is brought out so that this state machine can decode it, and so is the ALU zero flag. The memory is reached through an address, write data, write enable and read data. Read data must be valid in the same cycle as the address, and a write takes effect at the closing clock edge. The register file has `RF_DEPTH` entries. Register 0 always reads zero.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first PC write, `pc` equals `RESET_PC`. All holding registers and all register-file entries are zero at that point.
- R2: `mem_addr` is `pc` when `ctl_addr_sel`=0 and the ALU result register when it is 1. `mem_wdata` is the B operand register, and `mem_we` follows `ctl_mem_we`.
- R3: When `ctl_ir_we`=1, the instruction register (port `instr`) takes `mem_rdata` at the clock edge. Otherwise it keeps its value, even while later cycles read other memory words.
- R4: The first ALU operand is `pc` (`ctl_srca_sel`=0) or A (1). The second operand is selected by `ctl_srcb_sel`: 0 gives B, 1 gives the constant 4, 2 gives sign-extended `instr[15:0]`, and 3 gives that value shifted left by two. `ctl_alu_op` 0 selects add and 1 selects subtract. Any other value decodes the function field `instr[5:0]`: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0), and any other code add.
- R5: At every clock edge, A loads register `instr[25:21]` and B loads register `instr[20:16]`. At the same edge the ALU result register loads the ALU output and the memory data register loads `mem_rdata`.
- R6: With `ctl_rf_we`=1 the register file writes at the edge that ends the cycle. The destination is `instr[20:16]` when `ctl_dst_sel`=0 and `instr[15:11]` when it is 1. The data is the ALU result register when `ctl_wb_sel`=0 and the memory data register when it is 1.
- R7: Register 0, and any index of `RF_DEPTH` or above, reads as zero, and writes to it are discarded.
- R8: The PC source is selected by `ctl_pc_src`: 0 gives the live ALU output, 1 or 3 gives the ALU result register, and 2 gives `{pc[31:28], instr[25:0], 2'b00}`. `pc` loads this source when `ctl_pc_we`=1, or when `ctl_pc_we_cond`=1 and the ALU output is zero. Otherwise `pc` holds.
- R9: `alu_zero` is 1 exactly when the current ALU output is zero. For a branch, the PC therefore moves only when A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_wdata | output | 32 | Store data (B register) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| ctl_pc_we | input | 1 | Unconditional PC write |
| ctl_pc_we_cond | input | 1 | PC write qualified by ALU zero |
| ctl_addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| ctl_ir_we | input | 1 | Instruction register load |
| ctl_mem_we | input | 1 | Memory write request |
| ctl_rf_we | input | 1 | Register file write |
| ctl_dst_sel | input | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| ctl_wb_sel | input | 1 | Write-back source: 0 ALU result register, 1 memory data register |
| ctl_srca_sel | input | 1 | ALU operand A: 0 PC, 1 A register |
| ctl_srcb_sel | input | 2 | ALU operand B select |
| ctl_alu_op | input | 2 | ALU operation class |
| ctl_pc_src | input | 2 | PC source select |
| pc | output | 32 | Program counter |
| instr | output | 32 | Held instruction for the external decoder |
| alu_zero | output | 1 | ALU output equals zero |

## Verification
The bench builds the datapath with `RF_DEPTH`=8 and `RESET_PC`=0. The small register file lets the bench sweep every pair of source registers 0 to 6 against all five function codes. It also puts an out-of-range index (9) within reach, so that index can be shown to read zero and to drop writes without aliasing onto register 1. The bench plays the role of the control state machine and of the memory. It runs fetch, decode, execute, memory and write-back step sequences, and it reads register contents back through stores to memory. Branch checks cover taken and not-taken cases with positive and negative offsets, and jump checks cover a jump back to address 0.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

  localparam int DW   = 32;
  localparam int IDXW = 5;

  // ALU operand B selects
  localparam logic [1:0] SRCB_REG   = 2'd0;
  localparam logic [1:0] SRCB_FOUR  = 2'd1;
  localparam logic [1:0] SRCB_IMM   = 2'd2;
  localparam logic [1:0] SRCB_IMMW  = 2'd3;

  // ALU operation classes
  localparam logic [1:0] ALUOP_ADD  = 2'd0;
  localparam logic [1:0] ALUOP_SUB  = 2'd1;

  // PC source selects
  localparam logic [1:0] PCSRC_ALU  = 2'd0;
  localparam logic [1:0] PCSRC_JUMP = 2'd2;

  // function field codes
  localparam logic [5:0] FC_ADD = 6'h20;
  localparam logic [5:0] FC_SUB = 6'h22;
  localparam logic [5:0] FC_AND = 6'h24;
  localparam logic [5:0] FC_OR  = 6'h25;
  localparam logic [5:0] FC_SLT = 6'h2A;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT
  } alu_fn_e;

  function automatic logic [DW-1:0] sext16(input logic [15:0] v);
    return {{(DW-16){v[15]}}, v};
  endfunction

  function automatic alu_fn_e alu_decode(input logic [1:0] op, input logic [5:0] fc);
    alu_fn_e fn;
    if (op == ALUOP_ADD)      fn = FN_ADD;
    else if (op == ALUOP_SUB) fn = FN_SUB;
    else begin
      case (fc)
        FC_SUB:  fn = FN_SUB;
        FC_AND:  fn = FN_AND;
        FC_OR:   fn = FN_OR;
        FC_SLT:  fn = FN_SLT;
        default: fn = FN_ADD;
      endcase
    end
    return fn;
  endfunction

  function automatic logic [DW-1:0] alu_calc(input alu_fn_e fn,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW-1:0] r;
    case (fn)
      FN_SUB:  r = a - b;
      FN_AND:  r = a & b;
      FN_OR:   r = a | b;
      FN_SLT:  r = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] jump_target(input logic [DW-1:0] pc_v,
                                                input logic [25:0] field);
    return {pc_v[DW-1:DW-4], field, 2'b00};
  endfunction

endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int DEPTH = 32,
  parameter int IDXW  = 5,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] ra_idx,
  input  logic [IDXW-1:0] rb_idx,
  output logic [DW-1:0]   ra_data,
  output logic [DW-1:0]   rb_data,
  input  logic            we,
  input  logic [IDXW-1:0] wa,
  input  logic [DW-1:0]   wd
);
  localparam int SW = $clog2(DEPTH);

  logic [DW-1:0] store [1:DEPTH-1];

  // an index names a real entry only when nonzero and below DEPTH
  function automatic logic live(input logic [IDXW-1:0] idx);
    return (idx != '0) && ({1'b0, idx} < (IDXW+1)'(DEPTH));
  endfunction

  assign ra_data = live(ra_idx) ? store[ra_idx[SW-1:0]] : '0;
  assign rb_data = live(rb_idx) ? store[rb_idx[SW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 1; e < DEPTH; e++) store[e] <= '0;
    end else if (we && live(wa)) begin
      store[wa[SW-1:0]] <= wd;
    end
  end
endmodule

// File: rtl/mc_operand_sel.sv
`timescale 1ns/1ps
module mc_operand_sel
  import mc_pkg::*;
(
  input  logic          srca_sel,
  input  logic [1:0]    srcb_sel,
  input  logic [DW-1:0] pc_v,
  input  logic [DW-1:0] a_v,
  input  logic [DW-1:0] b_v,
  input  logic [15:0]   imm,
  output logic [DW-1:0] opa,
  output logic [DW-1:0] opb
);
  logic [DW-1:0] imm_x;
  assign imm_x = sext16(imm);
  assign opa   = srca_sel ? a_v : pc_v;

  always_comb begin
    case (srcb_sel)
      SRCB_REG:  opb = b_v;
      SRCB_FOUR: opb = DW'(4);
      SRCB_IMM:  opb = imm_x;
      default:   opb = {imm_x[DW-3:0], 2'b00};
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
(
  input  logic [1:0]    op,
  input  logic [5:0]    fcode,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  alu_fn_e fn;
  assign fn   = alu_decode(op, fcode);
  assign y    = alu_calc(fn, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          RF_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata,
  input  logic        ctl_pc_we,
  input  logic        ctl_pc_we_cond,
  input  logic        ctl_addr_sel,
  input  logic        ctl_ir_we,
  input  logic        ctl_mem_we,
  input  logic        ctl_rf_we,
  input  logic        ctl_dst_sel,
  input  logic        ctl_wb_sel,
  input  logic        ctl_srca_sel,
  input  logic [1:0]  ctl_srcb_sel,
  input  logic [1:0]  ctl_alu_op,
  input  logic [1:0]  ctl_pc_src,
  output logic [31:0] pc,
  output logic [31:0] instr,
  output logic        alu_zero
);
  // holding registers
  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;

  // named internal events
  logic [IDXW-1:0] rs_idx, rt_idx, rd_idx, rf_waddr;
  logic [DW-1:0]   rs_val, rt_val, rf_wdata;
  logic [DW-1:0]   opa, opb, alu_res, pc_next;
  logic            alu_zero_w, pc_write_en, rf_we_eff;

  assign rs_idx = ir_q[25:21];
  assign rt_idx = ir_q[20:16];
  assign rd_idx = ir_q[15:11];

  assign mem_addr  = ctl_addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl_mem_we;

  assign rf_waddr  = ctl_dst_sel ? rd_idx : rt_idx;
  assign rf_wdata  = ctl_wb_sel ? mdr_q : aluout_q;
  assign rf_we_eff = ctl_rf_we;

  mc_regfile #(.DEPTH(RF_DEPTH), .IDXW(IDXW), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (rs_idx),
    .rb_idx  (rt_idx),
    .ra_data (rs_val),
    .rb_data (rt_val),
    .we      (rf_we_eff),
    .wa      (rf_waddr),
    .wd      (rf_wdata)
  );

  mc_operand_sel u_opsel (
    .srca_sel (ctl_srca_sel),
    .srcb_sel (ctl_srcb_sel),
    .pc_v     (pc_q),
    .a_v      (a_q),
    .b_v      (b_q),
    .imm      (ir_q[15:0]),
    .opa      (opa),
    .opb      (opb)
  );

  mc_alu u_alu (
    .op    (ctl_alu_op),
    .fcode (ir_q[5:0]),
    .a     (opa),
    .b     (opb),
    .y     (alu_res),
    .zero  (alu_zero_w)
  );

  always_comb begin
    case (ctl_pc_src)
      PCSRC_ALU:  pc_next = alu_res;
      PCSRC_JUMP: pc_next = jump_target(pc_q, ir_q[25:0]);
      default:    pc_next = aluout_q;
    endcase
  end

  assign pc_write_en = ctl_pc_we | (ctl_pc_we_cond & alu_zero_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (ctl_ir_we)   ir_q <= mem_rdata;
      if (pc_write_en) pc_q <= pc_next;
      mdr_q    <= mem_rdata;
      a_q      <= rs_val;
      b_q      <= rt_val;
      aluout_q <= alu_res;
    end
  end

  assign pc       = pc_q;
  assign instr    = ir_q;
  assign alu_zero = alu_zero_w;
endmodule

// File: rtl/mc_datapath_chk.sv
`timescale 1ns/1ps
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] mem_rdata,
  input logic        ctl_ir_we,
  input logic        ctl_pc_we,
  input logic        ctl_pc_we_cond,
  input logic        alu_zero,
  input logic        pc_write_en,
  input logic [31:0] alu_res,
  input logic [31:0] aluout_q,
  input logic [31:0] rs_val
);
  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_write_en |=> $stable(pc));

  assert_branch_not_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we_cond && !ctl_pc_we && !alu_zero) |=> $stable(pc));

  assert_ir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_we |=> (instr == $past(mem_rdata)));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_we |=> $stable(instr));

  assert_aluout_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (aluout_q == $past(alu_res)));

  assert_reg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pc             (pc),
  .instr          (instr),
  .mem_rdata      (mem_rdata),
  .ctl_ir_we      (ctl_ir_we),
  .ctl_pc_we      (ctl_pc_we),
  .ctl_pc_we_cond (ctl_pc_we_cond),
  .alu_zero       (alu_zero),
  .pc_write_en    (pc_write_en),
  .alu_res        (alu_res),
  .aluout_q       (aluout_q),
  .rs_val         (rs_val)
);

// File: tb/mc_datapath_bench.sv
`timescale 1ns/1ps
module mc_datapath_bench;
  localparam int DEPTH_TB = 8;
  localparam logic [31:0] OUT_ADDR  = 32'h0000_0F00;
  localparam logic [31:0] DATA_ADDR = 32'h0000_0E00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc, instr;
  logic        mem_we, alu_zero;
  logic c_pc_we, c_pc_we_cond, c_addr_sel, c_ir_we, c_mem_we, c_rf_we;
  logic c_dst_sel, c_wb_sel, c_srca_sel;
  logic [1:0] c_srcb_sel, c_alu_op, c_pc_src;

  mc_datapath #(.RESET_PC(32'h0), .RF_DEPTH(DEPTH_TB)) u_mc_datapath (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .ctl_pc_we(c_pc_we), .ctl_pc_we_cond(c_pc_we_cond), .ctl_addr_sel(c_addr_sel),
    .ctl_ir_we(c_ir_we), .ctl_mem_we(c_mem_we), .ctl_rf_we(c_rf_we),
    .ctl_dst_sel(c_dst_sel), .ctl_wb_sel(c_wb_sel), .ctl_srca_sel(c_srca_sel),
    .ctl_srcb_sel(c_srcb_sel), .ctl_alu_op(c_alu_op), .ctl_pc_src(c_pc_src),
    .pc(pc), .instr(instr), .alu_zero(alu_zero)
  );

  // bench memory: combinational read, writes at the edge
  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    if (tb_we)  mem[tb_wa] <= tb_wd;
    if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
  end

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [31:0] exp_pc = 32'h0;
  logic [31:0] rv [0:7];

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] expv);
    nvec++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic idle();
    c_pc_we = 0; c_pc_we_cond = 0; c_addr_sel = 0; c_ir_we = 0; c_mem_we = 0;
    c_rf_we = 0; c_dst_sel = 0; c_wb_sel = 0; c_srca_sel = 0;
    c_srcb_sel = 2'd0; c_alu_op = 2'd0; c_pc_src = 2'd0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] data);
    idle();
    tb_we = 1'b1; tb_wa = addr[11:2]; tb_wd = data;
    step();
    tb_we = 1'b0;
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] f);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      6'h22:   return a + ~b + 32'd1;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  // fetch and decode; checks PC advance (R8, R4 constant 4) and IR capture (R3)
  task automatic fetch_decode(input logic [31:0] ins);
    poke(exp_pc, ins);
    idle();
    c_ir_we = 1; c_srcb_sel = 2'd1; c_pc_we = 1;
    step();
    check32("R3 instruction capture", instr, ins);
    check32("R8 pc+4 after fetch", pc, exp_pc + 32'd4);
    exp_pc = exp_pc + 32'd4;
    idle();
    c_srcb_sel = 2'd3;
    step();
  endtask

  task automatic do_j(input logic [25:0] tgt);
    fetch_decode({6'h02, tgt});
    idle();
    c_pc_src = 2'd2; c_pc_we = 1;
    step();
    exp_pc = {exp_pc[31:28], tgt, 2'b00};
    check32("R8 jump target", pc, exp_pc);
  endtask

  task automatic wrap();
    if (exp_pc >= 32'h800) do_j(26'd0);
  endtask

  task automatic do_lw(input int rt, input int rs, input logic [15:0] imm);
    wrap();
    fetch_decode(enc_i(6'h23, rs, rt, imm));
    idle(); c_srca_sel = 1; c_srcb_sel = 2'd2; step();
    idle(); c_addr_sel = 1; step();
    idle(); c_rf_we = 1; c_wb_sel = 1; step();
  endtask

  task automatic do_sw(input int rt, input int rs, input logic [15:0] imm);
    wrap();
    fetch_decode(enc_i(6'h2B, rs, rt, imm));
    idle(); c_srca_sel = 1; c_srcb_sel = 2'd2; step();
    idle(); c_addr_sel = 1; c_mem_we = 1; step();
    idle();
  endtask

  task automatic do_r(input int rs, input int rt, input int rd, input logic [5:0] f);
    wrap();
    fetch_decode(enc_r(rs, rt, rd, f));
    idle(); c_srca_sel = 1; c_alu_op = 2'd2; step();
    idle(); c_rf_we = 1; c_dst_sel = 1; step();
  endtask

  task automatic do_beq(input int rs, input int rt, input logic [15:0] off, input bit taken);
    logic [31:0] tgt;
    wrap();
    fetch_decode(enc_i(6'h04, rs, rt, off));
    tgt = exp_pc + {{14{off[15]}}, off, 2'b00};
    idle(); c_srca_sel = 1; c_alu_op = 2'd1; c_pc_src = 2'd1; c_pc_we_cond = 1;
    #1;
    check32("R9 zero flag on compare", {31'd0, alu_zero}, {31'd0, taken});
    step();
    if (taken) exp_pc = tgt;
    check32(taken ? "R8 branch taken pc" : "R9 branch not taken pc", pc, exp_pc);
  endtask

  // reads a register out through a store to OUT_ADDR
  task automatic check_reg(input int r, input logic [31:0] expv, input string req);
    poke(OUT_ADDR, ~expv);
    do_sw(r, 0, OUT_ADDR[15:0]);
    check32(req, mem[OUT_ADDR[11:2]], expv);
  endtask

  initial begin
    logic [5:0] fl [0:4];
    fl[0] = 6'h20; fl[1] = 6'h22; fl[2] = 6'h24; fl[3] = 6'h25; fl[4] = 6'h2A;
    rv[0] = 32'h0;         rv[1] = 32'h7FFF_FFFF; rv[2] = 32'h8000_0000;
    rv[3] = 32'hFFFF_FFFF; rv[4] = 32'h0000_0005; rv[5] = 32'h1234_5678;
    rv[6] = 32'hFFFF_FFFB; rv[7] = 32'h0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check32("R1 pc at reset", pc, 32'h0);
    check32("R1 instr at reset", instr, 32'h0);
    check32("R2 mem_we idle", {31'd0, mem_we}, 32'd0);
    check32("R2 address from pc", mem_addr, 32'h0);
    check32("R9 zero of 0+0 in reset", {31'd0, alu_zero}, 32'd1);
    rst_n = 1'b1;
    step();
    check32("R1 pc held after release", pc, 32'h0);
    check_reg(3, 32'h0, "R1 register cleared");

    // R5 R6 loads with wb from MDR into rt
    for (int k = 1; k < 7; k++) begin
      poke(DATA_ADDR + 32'(4*k), rv[k]);
      do_lw(k, 0, 16'(DATA_ADDR + 32'(4*k)));
    end
    for (int k = 1; k < 7; k++) check_reg(k, rv[k], "R6 load write-back");

    // R4 R5 R6 sweep of source pairs and function codes, result to register 7
    for (int s = 0; s < 7; s++)
      for (int t = 0; t < 7; t++)
        for (int f = 0; f < 5; f++) begin
          do_r(s, t, 7, fl[f]);
          check_reg(7, ref_alu(fl[f], rv[s], rv[t]), "R4 register op result");
        end

    // R4 unknown function code adds
    do_r(4, 5, 7, 6'h27);
    check_reg(7, rv[4] + rv[5], "R4 unknown function adds");

    // R7 register 0 and out-of-range index
    do_lw(0, 0, 16'(DATA_ADDR + 32'd4));
    check_reg(0, 32'h0, "R7 register 0 ignores write");
    do_r(4, 5, 9, 6'h20);
    check_reg(9, 32'h0, "R7 out-of-range reads zero");
    check_reg(1, rv[1], "R7 out-of-range no alias");

    // R2 R5 base+negative offset addressing
    poke(DATA_ADDR + 32'h40, DATA_ADDR + 32'h20);
    do_lw(7, 0, 16'(DATA_ADDR + 32'h40));
    poke(DATA_ADDR + 32'h1C, 32'hA5A5_0001);
    do_lw(2, 7, 16'hFFFC);
    check_reg(2, 32'hA5A5_0001, "R5 load with negative offset");
    poke(DATA_ADDR + 32'h18, 32'h0);
    do_sw(5, 7, 16'hFFF8);
    check32("R2 store address and data", mem[(DATA_ADDR + 32'h18) >> 2], rv[5]);

    // R8 R9 branches
    do_beq(4, 4, 16'd3, 1'b1);
    do_beq(4, 5, 16'd3, 1'b0);
    do_beq(0, 0, 16'hFFFD, 1'b1);
    do_beq(3, 6, 16'hFFFE, 1'b0);
    do_beq(3, 3, 16'd0, 1'b1);

    // R8 jumps
    do_j(26'h40);
    do_j(26'h10);
    do_j(26'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule